// File: doc/BRIEF.md
# Transaction Abort Policy Register

This block holds the policy that decides whether hardware transactions are forced to abort on a logical thread, and whether the two transaction feature bits are masked out of the feature word that enumeration returns. Software reaches two register views through a single request port. The first view is a plain control word: one bit turns transactions off and one bit hides the feature bits. The second view is a force-abort word. Its bits interact with each other and with two capability inputs.

The force-abort view exists only on parts that report the force-abort capability. Without that capability, any access to the view is rejected with an error flag. In the force-abort view:
- Bit 0 is computed on every read and cannot be written.
- Bit 1 is a second hide control, and it can only be set under conditions.
- Bit 2 is a development override. When set, it stops forced aborts and clears the reported always-abort capability.

The block registers its outputs. A processor pipeline uses them to abort transaction begins with a fixed code, to mask the feature word, and to tell the performance-monitoring logic whether counter 3 is free.

Top module: `txn_abort_policy`

## Requirements
- R1: While `rst` is high and on the first edge after it, every policy bit is 0, `rsp_valid`, `force_abort`, `hide_mask`, `eff_always_abort` and `ctr3_usable` are 0, and `abort_code` equals IDLE_CODE (all ones by default). The outputs then follow the capability inputs one edge later.
- R2: In the control view (`req_sel`=0), bit 0 is the disable bit. While it is 1, `force_abort` is 1 and `abort_code` is 0.
- R3: In the control view, bit 1 is the hide bit. While it is 1, `hide_mask` has bits HIDE_POS_A (11) and HIDE_POS_B (4) set, and every other bit is clear.
- R4: In the force view (`req_sel`=1), bit 0 always reads as the inverse of bit 2. A write to bit 0 changes nothing.
- R5: Force-abort is active when `cap_force_abort` is 1 and bit 2 is 0. While it is active, `force_abort` and `ctr3_usable` are 1 and `abort_code` is 0. While bit 2 is 1, `ctr3_usable` is 0.
- R6: Force-view bit 1 is the second hide bit.
  - It can change from 0 to 1 only when `cap_always_abort` is 1 or bit 2 is 1.
  - Writing 0 always clears it.
  - While it is 1, `hide_mask` sets the same two bits as R3.
- R7: Force-view bit 2 can change from 0 to 1 only when `cap_always_abort` is 0. Writing 0 always clears it.
- R8: `eff_always_abort` equals `cap_always_abort` while force-view bit 2 is 0, and is 0 while bit 2 is 1.
- R9: An access to the force view while `cap_force_abort` is 0 returns `rsp_err`=1 and `rsp_rdata`=0, and leaves all state unchanged.
- R10: Reserved bits read as 0.
  - In the control view, bits 2 and up are reserved.
  - In the force view, bits 3 and up are reserved.
  - A write with any reserved bit at 1 sets `rsp_rsvd`, and the reserved bits have no effect.
- R11: Each request gets exactly one response with `rsp_valid`=1 on the next edge. Read data is the view's value before the access. Writes return 0 as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = control view, 1 = force-abort view |
| req_wdata | input | DATA_W | Write data |
| cap_always_abort | input | 1 | Always-abort capability |
| cap_force_abort | input | 1 | Force-abort capability (force view present) |
| rsp_valid | output | 1 | Response strobe, one edge after the request |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Force view accessed without capability |
| rsp_rsvd | output | 1 | Write had a reserved bit set |
| force_abort | output | 1 | Transaction begins must abort |
| abort_code | output | CODE_W | 0 while forced, IDLE_CODE otherwise |
| hide_mask | output | FEAT_W | Feature-word bits to report as 0 |
| eff_always_abort | output | 1 | Reported always-abort capability |
| ctr3_usable | output | 1 | Counter 3 may be used |

## Verification
A wrong policy bit is visible at the ports one edge after the access that exposes it. It shows up in one of two ways: the next read of its view returns the wrong value, or `force_abort`, `hide_mask`, `eff_always_abort` or `ctr3_usable` changes at the same edge as the write. A gating condition that is too loose or too strict shows up in the same way. For example, bit 2 set while the always-abort capability is 1, or the second hide bit refusing a legal set, appear in the next read-back and in the forced-abort outputs. A rejected force-view access that leaks a write is caught by the read after the capability returns.

// File: rtl/txn_abort_pkg.sv
package txn_abort_pkg;
  typedef enum logic {
    VIEW_CTL   = 1'b0,
    VIEW_FORCE = 1'b1
  } view_e;
endpackage

// File: rtl/txn_ctl_view.sv
module txn_ctl_view #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              off_q,
  output logic              hide_q,
  output logic              off_nx,
  output logic              hide_nx,
  output logic              rsvd_hit
);
  localparam int USED_W = 2;

  assign rsvd_hit = |wdata[DATA_W-1:USED_W];
  assign off_nx   = wr_en ? wdata[0] : off_q;
  assign hide_nx  = wr_en ? wdata[1] : hide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= 1'b0;
      hide_q <= 1'b0;
    end else begin
      off_q  <= off_nx;
      hide_q <= hide_nx;
    end
  end

  // R2/R3: bits only move on a write
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(off_q) && $stable(hide_q)));
endmodule

// File: rtl/txn_force_view.sv
module txn_force_view #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cap_aa,
  output logic              dev_q,
  output logic              fhide_q,
  output logic              dev_nx,
  output logic              fhide_nx,
  output logic              rsvd_hit
);
  localparam int USED_W = 3;

  logic fhide_may_set, dev_may_set;

  assign rsvd_hit      = |wdata[DATA_W-1:USED_W];
  assign fhide_may_set = fhide_q | cap_aa | dev_q;
  assign dev_may_set   = dev_q | ~cap_aa;
  // bit 0 is computed on read; its write value is discarded
  assign fhide_nx = wr_en ? (wdata[1] & fhide_may_set) : fhide_q;
  assign dev_nx   = wr_en ? (wdata[2] & dev_may_set)   : dev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q   <= 1'b0;
      fhide_q <= 1'b0;
    end else begin
      dev_q   <= dev_nx;
      fhide_q <= fhide_nx;
    end
  end

  p_dev_set_gated_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_q) |-> !$past(cap_aa));
  p_fhide_set_gated_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fhide_q) |-> $past(cap_aa || dev_q));
endmodule

// File: rtl/txn_abort_policy.sv
module txn_abort_policy
  import txn_abort_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter int               FEAT_W     = 32,
  parameter int               HIDE_POS_A = 11,
  parameter int               HIDE_POS_B = 4,
  parameter int               CODE_W     = 8,
  parameter logic [CODE_W-1:0] IDLE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_always_abort,
  input  logic              cap_force_abort,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_rsvd,
  output logic              force_abort,
  output logic [CODE_W-1:0] abort_code,
  output logic [FEAT_W-1:0] hide_mask,
  output logic              eff_always_abort,
  output logic              ctr3_usable
);
  localparam logic [CODE_W-1:0] FORCED_CODE = '0;

  view_e sel;
  logic  hit_ctl, hit_force, force_ok, wr_ctl, wr_force;
  logic  off_q, hide_q, off_nx, hide_nx, ctl_rsvd;
  logic  dev_q, fhide_q, dev_nx, fhide_nx, frc_rsvd;
  logic  [DATA_W-1:0] view_ctl, view_force, rd_nx;
  logic  force_nx, hide_any_nx, ctr3_nx, eff_aa_nx, err_nx, rsvd_nx;
  logic  [FEAT_W-1:0] mask_nx;

  assign sel       = view_e'(req_sel);
  assign hit_ctl   = req_valid && sel == VIEW_CTL;
  assign hit_force = req_valid && sel == VIEW_FORCE;
  assign force_ok  = hit_force && cap_force_abort;
  assign wr_ctl    = hit_ctl && req_write;
  assign wr_force  = force_ok && req_write;

  txn_ctl_view #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_ctl), .wdata(req_wdata),
    .off_q(off_q), .hide_q(hide_q), .off_nx(off_nx), .hide_nx(hide_nx),
    .rsvd_hit(ctl_rsvd));

  txn_force_view #(.DATA_W(DATA_W)) u_force (
    .clk(clk), .rst(rst), .wr_en(wr_force), .wdata(req_wdata),
    .cap_aa(cap_always_abort), .dev_q(dev_q), .fhide_q(fhide_q),
    .dev_nx(dev_nx), .fhide_nx(fhide_nx), .rsvd_hit(frc_rsvd));

  always_comb begin
    view_ctl      = '0;
    view_ctl[0]   = off_q;
    view_ctl[1]   = hide_q;
    view_force    = '0;
    view_force[0] = ~dev_q;
    view_force[1] = fhide_q;
    view_force[2] = dev_q;
    rd_nx = '0;
    if (hit_ctl && !req_write)  rd_nx = view_ctl;
    if (force_ok && !req_write) rd_nx = view_force;
  end

  assign err_nx      = hit_force && !cap_force_abort;
  assign rsvd_nx     = (wr_ctl && ctl_rsvd) || (wr_force && frc_rsvd);
  assign force_nx    = off_nx | (cap_force_abort & ~dev_nx);
  assign hide_any_nx = hide_nx | (cap_force_abort & fhide_nx);
  assign ctr3_nx     = cap_force_abort & ~dev_nx;
  assign eff_aa_nx   = cap_always_abort & ~dev_nx;

  for (genvar i = 0; i < FEAT_W; i++) begin : g_mask
    if (i == HIDE_POS_A || i == HIDE_POS_B) begin : g_hit
      assign mask_nx[i] = hide_any_nx;
    end else begin : g_keep
      assign mask_nx[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid        <= 1'b0;
      rsp_rdata        <= '0;
      rsp_err          <= 1'b0;
      rsp_rsvd         <= 1'b0;
      force_abort      <= 1'b0;
      abort_code       <= IDLE_CODE;
      hide_mask        <= '0;
      eff_always_abort <= 1'b0;
      ctr3_usable      <= 1'b0;
    end else begin
      rsp_valid        <= req_valid;
      rsp_rdata        <= rd_nx;
      rsp_err          <= err_nx;
      rsp_rsvd         <= rsvd_nx;
      force_abort      <= force_nx;
      abort_code       <= force_nx ? FORCED_CODE : IDLE_CODE;
      hide_mask        <= mask_nx;
      eff_always_abort <= eff_aa_nx;
      ctr3_usable      <= ctr3_nx;
    end
  end

  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));
  p_err_no_data_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == '0 && !rsp_rsvd));
  p_ctr3_forced_r5: assert property (@(posedge clk) disable iff (rst)
    ctr3_usable |-> (force_abort && abort_code == FORCED_CODE));
  p_eff_aa_cap_r8: assert property (@(posedge clk) disable iff (rst)
    eff_always_abort |-> $past(cap_always_abort));
  p_dev_blocks_ctr3_r5: assert property (@(posedge clk) disable iff (rst)
    dev_q |-> !ctr3_usable);
endmodule

// File: tb/test_txn_abort_policy.sv
module test_txn_abort_policy;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int FEAT_W = 32;
  localparam int CODE_W = 8;

  logic clk = 1'b0;
  logic rst, req_valid, req_write, req_sel, cap_aa, cap_fa;
  logic [DATA_W-1:0] req_wdata, rsp_rdata;
  logic rsp_valid, rsp_err, rsp_rsvd, force_abort, eff_always_abort, ctr3_usable;
  logic [CODE_W-1:0] abort_code;
  logic [FEAT_W-1:0] hide_mask;

  int n_chk = 0, n_fail = 0;
  bit m_off, m_hide, m_fhide, m_dev;

  always #(CLK_P/2) clk = ~clk;

  txn_abort_policy i_txn_abort_policy (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .cap_always_abort(cap_aa),
    .cap_force_abort(cap_fa), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .rsp_rsvd(rsp_rsvd), .force_abort(force_abort),
    .abort_code(abort_code), .hide_mask(hide_mask),
    .eff_always_abort(eff_always_abort), .ctr3_usable(ctr3_usable));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_view(bit s);
    logic [DATA_W-1:0] v = '0;
    if (!s) begin v[0] = m_off; v[1] = m_hide; end
    else begin v[0] = !m_dev; v[1] = m_fhide; v[2] = m_dev; end
    return v;
  endfunction

  function automatic logic [FEAT_W-1:0] exp_mask();
    logic [FEAT_W-1:0] v = '0;
    if (m_hide || (cap_fa && m_fhide)) begin v[11] = 1'b1; v[4] = 1'b1; end
    return v;
  endfunction

  task automatic check_outs(string tag);
    bit f = m_off || (cap_fa && !m_dev);
    check({tag, " R2/R5 force_abort"}, force_abort, f);
    check({tag, " R2/R5 abort_code"}, abort_code, f ? 0 : 8'hFF);
    check({tag, " R3/R6 hide_mask"}, hide_mask, exp_mask());
    check({tag, " R8 eff_always_abort"}, eff_always_abort, cap_aa && !m_dev);
    check({tag, " R5 ctr3_usable"}, ctr3_usable, cap_fa && !m_dev);
  endtask

  task automatic access(bit wr, bit s, logic [DATA_W-1:0] wd, string tag);
    bit err, rsvd;
    logic [DATA_W-1:0] rd;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_sel = s; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    err  = s && !cap_fa;
    rd   = (wr || err) ? '0 : exp_view(s);
    rsvd = wr && !err && (s ? |wd[DATA_W-1:3] : |wd[DATA_W-1:2]);
    if (wr && !err) begin
      if (!s) begin m_off = wd[0]; m_hide = wd[1]; end
      else begin
        m_fhide = wd[1] && (m_fhide || cap_aa || m_dev);
        m_dev   = wd[2] && (m_dev || !cap_aa);
      end
    end
    check({tag, " R11 rsp_valid"}, rsp_valid, 1);
    check({tag, " R4/R10/R11 rdata"}, rsp_rdata, rd);
    check({tag, " R9 rsp_err"}, rsp_err, err);
    check({tag, " R10 rsp_rsvd"}, rsp_rsvd, rsvd);
    check_outs(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_sel = 0; req_wdata = '0;
    cap_aa = 0; cap_fa = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 force_abort", force_abort, 0);
    check("R1 abort_code", abort_code, 8'hFF);
    check("R1 hide_mask", hide_mask, 0);
    check("R1 ctr3", ctr3_usable, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    rst = 0;
    @(negedge clk);
    check_outs("R1 post-reset");
    access(0, 1, '0, "R4 read force");
    access(1, 1, 32'h1, "R4 write bit0");
    access(0, 1, '0, "R4 readback");
    access(1, 1, 32'h2, "R6 fhide blocked");
    access(0, 1, '0, "R6 readback");
    access(1, 1, 32'h4, "R7 dev set");
    access(1, 1, 32'h6, "R6 fhide via dev");
    access(0, 1, '0, "R4/R6 readback");
    access(1, 1, 32'h0, "R7 clear");
    cap_aa = 1;
    access(1, 1, 32'h4, "R7 dev blocked");
    access(1, 1, 32'h2, "R6 fhide via cap");
    access(0, 1, '0, "R7 readback");
    access(1, 0, 32'h1, "R2 off");
    access(1, 0, 32'hFFFF_FFF2, "R3/R10 hide rsvd");
    access(0, 0, '0, "R10 readback");
    cap_fa = 0;
    access(1, 1, 32'h0, "R9 denied write");
    access(0, 1, '0, "R9 denied read");
    access(1, 0, 32'h0, "R2 clear");
    cap_fa = 1;
    access(0, 1, '0, "R9 state kept");
    access(1, 1, 32'hF000_0000, "R10 force rsvd");
    for (int i = 0; i < 400; i++) begin
      logic [DATA_W-1:0] wd = $urandom(i + 7) & 32'h7;
      if ($urandom % 8 == 0) wd = wd | ($urandom << 3);
      if ($urandom % 6 == 0) cap_aa = $urandom;
      if ($urandom % 10 == 0) cap_fa = $urandom;
      access($urandom, $urandom, wd, "random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule